// File: doc/BRIEF.md
# Configuration Word Read and Semaphore Register Slave

This block sits on a simple 32-bit register port. Host software uses it to read 16-bit words from a small on-chip configuration store. It also uses it for a lock handshake with firmware. The store holds 64 words of 16 bits. Its contents are written through a separate image-load port before use.

A word read takes one register write. Software writes the lookup register with a word address and the start bit set. On the next clock the register shows:
- the fetched word in its upper half;
- the done flag set;
- the start bit clear.

A software lock register and a firmware lock register carry the ownership handshake:
- Reading the software lock register returns its current value, then sets its lock bit.
- Software cannot claim the store bit while firmware holds its own lock.
- The firmware register changes only through a dedicated test port.

A fourth register is a free 32-bit scratch word shared by both sides.

Top module: `eeprom_sema_regs`

## Requirements
- R1: After reset, all four registers read as zero. The registers are selected by `reg_sel`: 0 = lookup, 1 = software lock, 2 = firmware lock, 3 = scratch.
- R2: A write to the lookup register with bit 0 (start) set updates the register on the next clock. It then reads bits 31:16 = stored word at the address given in bits 15:2, bits 15:2 = that address, bit 1 (done) = 1, and bit 0 = 0.
- R3: A start request whose address is 64 or more returns word 0 and still sets done. Bits 31:16 of the write data are ignored.
- R4: A write to the lookup register with bit 0 clear stores bits 15:0 as written and leaves bits 31:16 unchanged.
- R5: A read of the software lock register (`reg_re`) returns the value held before the read. From the next clock, bit 0 reads as 1.
- R6: A write to the software lock register stores write-data bits 2:0: bit 0 lock, bit 1 store claim, bit 2 wake request. Bits 31:3 always read 0.
- R7: While firmware lock bit 0 is 1, a software lock write stores bit 1 as 0. While it is 0, bit 1 is stored as written.
- R8: Bus writes to the firmware lock register have no effect. A `fw_we` load stores only the firmware fields: bit 0 lock, bits 3:1 mode, bit 15 valid, bits 18:16 reset count. All other bits read 0.
- R9: The scratch register stores and returns all 32 bits.
- R10: An `img_we` pulse writes `img_data` into the word at `img_addr`. Later lookups of that address return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (drives read side effects) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel`, combinational |
| img_we | input | 1 | Image word write strobe |
| img_addr | input | 6 | Image word index |
| img_data | input | 16 | Image word value |
| fw_we | input | 1 | Firmware register load strobe (test port) |
| fw_wdata | input | 32 | Firmware register load value |

## Verification
The lock-after-read property assumes that `reg_re` and `reg_we` are never high together on the software lock register. On that collision the write wins and the read's side effect is lost. The bench drives reads and writes in separate cycles, so the assumption always holds.

The properties also assume that every image word was loaded before it is looked up. The bench loads all 64 words while the block is still in reset. Every expected value is taken from the same address-to-word function that produced the image.

// File: rtl/eeprom_sema_regs.sv
module eeprom_sema_regs #(
  parameter int WORDS   = 64,
  parameter int WORD_W  = 16,
  parameter int EADDR_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               reg_sel,
  input  logic                     reg_we,
  input  logic                     reg_re,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic                     img_we,
  input  logic [$clog2(WORDS)-1:0] img_addr,
  input  logic [WORD_W-1:0]        img_data,
  input  logic                     fw_we,
  input  logic [31:0]              fw_wdata
);
  localparam int IW = $clog2(WORDS);
  localparam logic [1:0] SEL_EE = 2'd0, SEL_SW = 2'd1, SEL_FW = 2'd2, SEL_SY = 2'd3;
  localparam logic [31:0] FW_MASK = 32'h0007_800F;
  localparam logic [EADDR_W-1:0] LIMIT = EADDR_W'(WORDS);

  logic [WORD_W-1:0] mem [WORDS];
  logic [31:0] ee_q, fw_q, sync_q;
  logic [2:0]  sw_q;

  always_ff @(posedge clk)
    if (img_we) mem[img_addr] <= img_data;

  wire ee_wr = reg_we && reg_sel == SEL_EE;
  wire sw_wr = reg_we && reg_sel == SEL_SW;
  wire sw_rd = reg_re && !reg_we && reg_sel == SEL_SW;
  wire [EADDR_W-1:0] req_addr = reg_wdata[EADDR_W+1:2];
  wire in_range = req_addr < LIMIT;
  wire [WORD_W-1:0] fetched = in_range ? mem[req_addr[IW-1:0]] : '0;

  always_ff @(posedge clk)
    if (!rst_n)
      ee_q <= '0;
    else if (ee_wr) begin
      if (reg_wdata[0]) ee_q <= {fetched, req_addr, 1'b1, 1'b0};
      else              ee_q <= {ee_q[31:16], reg_wdata[15:0]};
    end

  always_ff @(posedge clk)
    if (!rst_n)      sw_q <= '0;
    else if (sw_wr)  sw_q <= {reg_wdata[2], reg_wdata[1] & ~fw_q[0], reg_wdata[0]};
    else if (sw_rd)  sw_q[0] <= 1'b1;

  always_ff @(posedge clk)
    if (!rst_n)      fw_q <= '0;
    else if (fw_we)  fw_q <= fw_wdata & FW_MASK;

  always_ff @(posedge clk)
    if (!rst_n)                               sync_q <= '0;
    else if (reg_we && reg_sel == SEL_SY)     sync_q <= reg_wdata;

  always_comb
    case (reg_sel)
      SEL_EE:  reg_rdata = ee_q;
      SEL_SW:  reg_rdata = {29'd0, sw_q};
      SEL_FW:  reg_rdata = fw_q;
      default: reg_rdata = sync_q;
    endcase

  // R2
  ee_start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_EE && reg_wdata[0]) |=> (ee_q[1] && !ee_q[0]));

  // R3
  ee_oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_EE && reg_wdata[0] && reg_wdata[EADDR_W+1:2] >= LIMIT)
      |=> (ee_q[31:16] == '0));

  // R4
  ee_hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_EE && !reg_wdata[0]) |=> $stable(ee_q[31:16]));

  // R5
  sw_lock_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !reg_we && reg_sel == SEL_SW) |=> reg_rdata[0] || reg_sel != SEL_SW);

  // R7
  sw_fw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_SW && fw_q[0]) |=> !sw_q[1]);

  // R8
  fw_bus_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_we |=> $stable(fw_q));
endmodule

// File: tb/tb_eeprom_sema_regs.sv
module tb_eeprom_sema_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_sel = 0;
  logic reg_we = 0, reg_re = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic img_we = 0;
  logic [5:0] img_addr = 0;
  logic [15:0] img_data = 0;
  logic fw_we = 0;
  logic [31:0] fw_wdata = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_sema_regs dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .img_we(img_we),
    .img_addr(img_addr), .img_data(img_data), .fw_we(fw_we), .fw_wdata(fw_wdata));

  function automatic logic [15:0] img_word(int i);
    return 16'((i * 16'h0321) ^ 16'hBA00);
  endfunction

  // {we, sel, wdata, check_sel, expected}
  localparam logic [68:0] VEC [0:10] = '{
    {1'b1, 2'd0, 32'h0000_0015, 2'd0, {img_word(5),  14'd5,  2'b10}},   // R2
    {1'b1, 2'd0, 32'h0000_00FD, 2'd0, {img_word(63), 14'd63, 2'b10}},   // R2 last word
    {1'b1, 2'd0, 32'h0000_0101, 2'd0, {16'h0000,     14'd64, 2'b10}},   // R3 first out
    {1'b1, 2'd0, 32'hFFFF_FFFD, 2'd0, {16'h0000, 14'h3FFF, 2'b10}},     // R3 max addr
    {1'b1, 2'd0, 32'h0000_001D, 2'd0, {img_word(7),  14'd7,  2'b10}},   // R2
    {1'b1, 2'd0, 32'hABCD_0026, 2'd0, {img_word(7),  14'd9,  2'b10}},   // R4
    {1'b1, 2'd0, 32'h0000_0001, 2'd0, {img_word(0),  14'd0,  2'b10}},   // R2 word 0
    {1'b1, 2'd3, 32'hDEAD_BEEF, 2'd3, 32'hDEAD_BEEF},                   // R9
    {1'b1, 2'd1, 32'hFFFF_FFFF, 2'd1, 32'h0000_0007},                   // R6
    {1'b1, 2'd2, 32'h0000_1234, 2'd2, 32'h0000_0000},                   // R8
    {1'b1, 2'd3, 32'h0000_0000, 2'd3, 32'h0000_0000}                    // R9
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] s, logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic peek(logic [1:0] s, output logic [31:0] v);
    reg_sel = s; #1 v = reg_rdata;
  endtask

  task automatic bus_read(logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s; reg_re = 1; #1 v = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic fw_load(logic [31:0] d);
    @(negedge clk); fw_we = 1; fw_wdata = d;
    @(negedge clk); fw_we = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); img_we = 1; img_addr = 6'(i); img_data = img_word(i);
    end
    @(negedge clk); img_we = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < 4; s++) begin
      peek(2'(s), v); check("R1 reset", v, 32'h0);
    end

    for (int k = 0; k < 11; k++) begin
      logic [68:0] e = VEC[k];
      if (e[68]) bus_write(e[67:66], e[65:34]);
      peek(e[33:32], v);
      check($sformatf("vector %0d (R2/R3/R4/R6/R8/R9)", k), v, e[31:0]);
    end

    // R10: reload one word and look it up
    @(negedge clk); img_we = 1; img_addr = 6'd12; img_data = 16'h5A5A;
    @(negedge clk); img_we = 0;
    bus_write(2'd0, 32'h0000_0031);
    peek(2'd0, v); check("R10 reload", v, {16'h5A5A, 14'd12, 2'b10});

    // R5: read returns old value, then lock bit reads 1
    bus_write(2'd1, 32'h0000_0004);
    bus_read(2'd1, v); check("R5 first read", v, 32'h4);
    peek(2'd1, v); check("R5 lock set", v, 32'h5);
    bus_read(2'd1, v); check("R5 second read", v, 32'h5);

    // R8: firmware fields via test port only
    fw_load(32'hFFFF_FFFF);
    peek(2'd2, v); check("R8 fw mask", v, 32'h0007_800F);
    bus_write(2'd2, 32'h0);
    peek(2'd2, v); check("R8 bus ignored", v, 32'h0007_800F);

    // R7: claim refused while firmware holds lock
    bus_write(2'd1, 32'h0000_0006);
    peek(2'd1, v); check("R7 blocked", v, 32'h4);
    fw_load(32'h0000_0000);
    bus_write(2'd1, 32'h0000_0002);
    peek(2'd1, v); check("R7 allowed", v, 32'h2);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int s = 0; s < 4; s++) begin
      peek(2'(s), v); check("R1 re-reset", v, 32'h0);
    end
    finish_run();
  end
endmodule